// File: doc/BRIEF.md
# TMDS Clock Lane Pattern Shifter

This block produces the 10-bit word sent on the clock lane of a TMDS transmitter. It works from a 40-bit clock pattern that is held as four 10-bit segments. Segment k covers bits 10k+9 down to 10k, so segment 0 is bits 9:0 and segment 3 is bits 39:30. A load strobe copies the pattern presented at the input into a working register. Changes at that input have no effect until the next load.

When shifting is enabled, the output steps through the four segments, one per clock, in the order 0, 1, 2, 3, and then wraps. One clock period therefore spans 40 bit times, which gives a clock lane at one quarter of the character rate. When shifting is disabled, the output stays on segment 0. A load always restarts the sequence at segment 0. For divide-by-four operation the usual pattern has bits 19:0 set and bits 39:20 clear. Serialization of the word happens downstream and is not part of this block.

Top module: `tmds_clk_pattern_shifter`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises with no load, word_o is all zeros. Reset clears the working pattern and the segment index is 0.
- R2: A high load_i at a rising clock edge copies pattern_i into the working pattern. Without a load, later changes on pattern_i leave word_o unchanged.
- R3: In the cycle after a load edge, word_o equals bits 9:0 of the loaded pattern, whatever the level of shift_en_i.
- R4: While shift_en_i is high and load_i is low, each clock edge advances the shown segment by one: bits 9:0, then 19:10, then 29:20, then 39:30, then back to bits 9:0.
- R5: After any clock edge that samples shift_en_i low, word_o shows bits 9:0 of the working pattern. Disabling shifting partway through the sequence returns the output to segment 0, and a later enable continues from segment 1.
- R6: When load_i and shift_en_i are both high at an edge, the load takes priority. The next cycle shows bits 9:0 of the new pattern, and the cycle after that shows its bits 19:10.
- R7: With the working pattern 40'h00000FFFFF and shifting on, word_o repeats 10'h3FF, 10'h3FF, 10'h000, 10'h000. Each 40-bit period therefore holds 20 ones followed by 20 zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pattern_i | input | 40 | Programmed clock pattern, captured on load |
| load_i | input | 1 | Copies pattern_i into the working pattern and restarts at segment 0 |
| shift_en_i | input | 1 | 1 = rotate through the segments, 0 = hold segment 0 |
| word_o | output | 10 | Current 10-bit clock lane word |

## Verification
Some rules are checked by assertions on every cycle:
- the working pattern changes only on a load, and takes the value that pattern_i had at that load;
- the segment index stays in range and steps by one with wrap while shifting;
- the index falls to zero after a load or while shifting is off;
- word_o shows the low segment of the loaded pattern in the cycle after a load.

Other properties need the directed scenarios to show them:
- the full segment order over the actual bit fields;
- that pattern_i is ignored between loads;
- that enabling again after a stop resumes from segment 1;
- the 20-high, 20-low waveform of the divide-by-four pattern.

// File: rtl/tcps_pkg.sv
package tcps_pkg;
    localparam int unsigned TCPS_SEG_W   = 10;
    localparam int unsigned TCPS_NUM_SEG = 4;
endpackage

// File: rtl/tcps_pattern_store.sv
module tcps_pattern_store #(
    parameter int unsigned PAT_W = 40
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [PAT_W-1:0] pattern_i,
    output logic [PAT_W-1:0] pat_o
);
    typedef struct packed {
        logic [PAT_W-1:0] pat;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.pat = pattern_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pat_o = st_q.pat;

    AST_PAT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (st_q.pat == $past(pattern_i))); // R2

    AST_PAT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(st_q.pat)); // R2
endmodule

// File: rtl/tcps_seg_seq.sv
module tcps_seg_seq #(
    parameter int unsigned NUM_SEG = 4,
    localparam int unsigned IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             shift_en_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SEG - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        if (load_i) begin
            sq_d.idx = '0;
        end else if (shift_en_i) begin
            if (sq_q.idx == LAST_IDX) begin
                sq_d.idx = '0;
            end else begin
                sq_d.idx = sq_q.idx + IDX_W'(1);
            end
        end else begin
            sq_d.idx = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign idx_o = sq_q.idx;

    AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sq_q.idx <= LAST_IDX); // R4

    AST_LOAD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (sq_q.idx == '0)); // R6

    AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shift_en_i && !load_i) |=> (sq_q.idx == '0)); // R5

    AST_SEG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_en_i && !load_i) |=>
            (sq_q.idx == (($past(sq_q.idx) == LAST_IDX) ? '0
                          : IDX_W'($past(sq_q.idx) + IDX_W'(1))))); // R4
endmodule

// File: rtl/tcps_seg_mux.sv
module tcps_seg_mux #(
    parameter int unsigned SEG_W   = 10,
    parameter int unsigned NUM_SEG = 4,
    localparam int unsigned PAT_W  = SEG_W * NUM_SEG,
    localparam int unsigned IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic [PAT_W-1:0] pat_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [SEG_W-1:0] word_o
);
    logic [SEG_W-1:0] segs [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        assign segs[g] = pat_i[g*SEG_W +: SEG_W];
    end

    always_comb begin
        word_o = '0;
        for (int k = 0; k < NUM_SEG; k++) begin
            if (idx_i == IDX_W'(k)) begin
                word_o = segs[k];
            end
        end
    end
endmodule

// File: rtl/tmds_clk_pattern_shifter.sv
module tmds_clk_pattern_shifter #(
    parameter int unsigned SEG_W   = tcps_pkg::TCPS_SEG_W,
    parameter int unsigned NUM_SEG = tcps_pkg::TCPS_NUM_SEG,
    localparam int unsigned PAT_W  = SEG_W * NUM_SEG,
    localparam int unsigned IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PAT_W-1:0] pattern_i,
    input  logic             load_i,
    input  logic             shift_en_i,
    output logic [SEG_W-1:0] word_o
);
    logic [PAT_W-1:0] work_pat;
    logic [IDX_W-1:0] seg_idx;

    tcps_pattern_store #(.PAT_W(PAT_W)) store_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load_i),
        .pattern_i (pattern_i),
        .pat_o     (work_pat)
    );

    tcps_seg_seq #(.NUM_SEG(NUM_SEG)) seq_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load_i),
        .shift_en_i (shift_en_i),
        .idx_o      (seg_idx)
    );

    tcps_seg_mux #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) mux_i (
        .pat_i  (work_pat),
        .idx_i  (seg_idx),
        .word_o (word_o)
    );

    AST_LOAD_SHOWS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (word_o == $past(pattern_i[SEG_W-1:0]))); // R3
endmodule

// File: tb/tmds_clk_pattern_shifter_tb.sv
`timescale 1ns/1ps
module tmds_clk_pattern_shifter_tb_top;
    logic        clk = 1'b0;
    logic        rst_ni;
    logic [39:0] pattern_i;
    logic        load_i;
    logic        shift_en_i;
    logic [9:0]  word_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tmds_clk_pattern_shifter dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_ni),
        .pattern_i  (pattern_i),
        .load_i     (load_i),
        .shift_en_i (shift_en_i),
        .word_o     (word_o)
    );

    function automatic logic [9:0] seg_of(input logic [39:0] p, input int k);
        return p[k*10 +: 10];
    endfunction

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [39:0] p, input logic sh);
        pattern_i  = p;
        load_i     = 1'b1;
        shift_en_i = sh;
        tick();
        load_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_ni = 1'b0; pattern_i = '0; load_i = 1'b0; shift_en_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 in reset", {30'd0, word_o}, 40'd0);
        rst_ni = 1'b1;
        tick();
        check("R1 after release", {30'd0, word_o}, 40'd0);
    endtask

    task automatic t_load_hold();
        logic [39:0] p = 40'h9A_5C3F_17E2;
        do_load(p, 1'b0);
        check("R3 low segment after load", {30'd0, word_o}, {30'd0, seg_of(p, 0)});
        pattern_i = ~p;
        tick();
        check("R2 input ignored without load", {30'd0, word_o}, {30'd0, seg_of(p, 0)});
        tick();
        check("R5 hold segment 0", {30'd0, word_o}, {30'd0, seg_of(p, 0)});
    endtask

    task automatic t_rotate();
        logic [39:0] p = 40'h3C_96A5_0F71;
        do_load(p, 1'b0);
        check("R3 start segment", {30'd0, word_o}, {30'd0, seg_of(p, 0)});
        shift_en_i = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            tick();
            check("R4 rotation", {30'd0, word_o}, {30'd0, seg_of(p, i % 4)});
        end
        shift_en_i = 1'b0;
        tick();
    endtask

    task automatic t_disable_mid();
        logic [39:0] p = 40'hE1_2B4D_6F80;
        do_load(p, 1'b0);
        shift_en_i = 1'b1;
        tick();
        tick();
        check("R4 at segment 2", {30'd0, word_o}, {30'd0, seg_of(p, 2)});
        shift_en_i = 1'b0;
        tick();
        check("R5 back to segment 0", {30'd0, word_o}, {30'd0, seg_of(p, 0)});
        tick();
        check("R5 stays at segment 0", {30'd0, word_o}, {30'd0, seg_of(p, 0)});
        shift_en_i = 1'b1;
        tick();
        check("R5 resume at segment 1", {30'd0, word_o}, {30'd0, seg_of(p, 1)});
        shift_en_i = 1'b0;
        tick();
    endtask

    task automatic t_load_priority();
        logic [39:0] a = 40'h55_AA33_CC0F;
        logic [39:0] b = 40'h1F_E0D2_7B49;
        do_load(a, 1'b1);
        tick();
        tick();
        check("R4 before reload", {30'd0, word_o}, {30'd0, seg_of(a, 2)});
        do_load(b, 1'b1);
        check("R6 load wins over shift", {30'd0, word_o}, {30'd0, seg_of(b, 0)});
        tick();
        check("R6 next segment of new pattern", {30'd0, word_o}, {30'd0, seg_of(b, 1)});
        shift_en_i = 1'b0;
        tick();
    endtask

    task automatic t_div4();
        logic [39:0] p = 40'h00000FFFFF;
        logic [39:0] bits;
        logic [9:0]  exp_w [4];
        int ones;
        exp_w[0] = 10'h3FF; exp_w[1] = 10'h3FF; exp_w[2] = 10'h000; exp_w[3] = 10'h000;
        do_load(p, 1'b1);
        for (int per = 0; per < 2; per++) begin
            bits = '0;
            for (int w = 0; w < 4; w++) begin
                check("R7 divide-by-four word", {30'd0, word_o}, {30'd0, exp_w[w]});
                bits[w*10 +: 10] = word_o;
                tick();
            end
            ones = $countones(bits);
            check("R7 ones per 40-bit period", 40'(ones), 40'd20);
            check("R7 period waveform", bits, 40'h00000FFFFF);
        end
    endtask

    task automatic t_reset_mid();
        do_load(40'hFF_FFFF_FFFF, 1'b1);
        rst_ni = 1'b0;
        #1;
        check("R1 reset mid-run", {30'd0, word_o}, 40'd0);
        shift_en_i = 1'b0;
        @(negedge clk);
        rst_ni = 1'b1;
        tick();
        check("R1 pattern cleared by reset", {30'd0, word_o}, 40'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_load_hold();
        t_rotate();
        t_disable_mid();
        t_load_priority();
        t_div4();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule